// File: doc/BRIEF.md
# Sleep and Wake Power-Mode Controller

This block sits next to a two-wire serial slave front end and decides when the device may enter and leave a low-power sleep state. The front end reports decoded bus events: a slave-address byte and which of the device's three identities it matched, a register-address byte, a data byte, a stop and an aborted or not-acknowledged transfer. The controller watches these events for one specific write, the sleep command. That write goes to the control identity, targets command register 0xAA and carries the sleep code 0xB9.

Once the command has been registered at the stop, the controller waits a processing interval. It then asks the memory side for a save of volatile contents, but only if the memory was written since the last save or recall. When the save is finished and the sleep interval has run out, it enters sleep. While the device is going to sleep, is asleep, or is waking up, the block stops the front end from acknowledging anything. While asleep, any byte that matches one of the three slave identities starts a wake timer. When that timer expires, the device is accessible again.

All intervals are parameters counted in clock cycles: `T_SS` for processing, `T_SLEEP` for the sleep interval and `T_WAKE` for the wake interval. `T_SLEEP` must be larger than `T_SS`.

Top module: `sleep_ctl_top`

## Requirements
- R1: After reset, `pwr_state` is ACTIVE (0), `ack_en` is 1, `store_req` is 0, `busy_n` is 1 and `asleep` is 0.
- R2: A transaction matching the sleep command moves `pwr_state` to SLEEP_PENDING (1) in the cycle after its stop is sampled. The transaction is an address event with `addr_sel` = 2 and `addr_rw` = 0, then a register byte 0xAA, then exactly one data byte 0xB9, then `stop_evt`, with no `xfer_abort`.
- R3: Any other transaction leaves `pwr_state` at ACTIVE. This covers another selector, a read, another register, another data value, a second data byte, and an abort before the stop.
- R4: SLEEP_PENDING lasts `T_SS` cycles, after which `pwr_state` is STORING (2).
- R5: In STORING with a save needed, `store_req` is 1 and `busy_n` is 0 until `store_done` is sampled. In the following cycle `store_req` is 0 and `busy_n` is 1.
- R6: A save is needed only if `mem_wr` was sampled since the last `store_done` or `recall_evt`. Without one, `store_req` stays 0 throughout the sleep entry.
- R7: ASLEEP (3) begins in the first cycle where at least `T_SLEEP` cycles have passed since the stop was registered and no save is outstanding. `asleep` is 1 only in ASLEEP.
- R8: In ASLEEP, an address event with `addr_sel` of 1, 2 or 3 moves `pwr_state` to WAKING (4) in the next cycle. `addr_sel` = 0 is ignored.
- R9: WAKING lasts `T_WAKE` cycles from the first waking address, then `pwr_state` returns to ACTIVE. Further addresses during WAKING do not restart the interval.
- R10: `ack_en` is 0 in every state other than ACTIVE, so all accesses in that time are refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_evt | input | 1 | Slave-address byte received this cycle |
| addr_sel | input | 2 | Matched identity: 0 none, 1 memory, 2 control, 3 clock |
| addr_rw | input | 1 | Direction bit of the address byte (1 = read) |
| reg_evt | input | 1 | Register-address byte received |
| reg_byte | input | 8 | Register-address value |
| data_evt | input | 1 | Data byte received |
| data_byte | input | 8 | Data value |
| stop_evt | input | 1 | Stop condition seen |
| xfer_abort | input | 1 | Transfer aborted or a byte not acknowledged |
| mem_wr | input | 1 | Volatile memory written |
| recall_evt | input | 1 | Recall of volatile contents completed |
| store_done | input | 1 | Save of volatile contents finished |
| ack_en | output | 1 | Front end may acknowledge |
| store_req | output | 1 | Save request, held until done |
| busy_n | output | 1 | Low while a save for sleep is in progress |
| asleep | output | 1 | Low-power state active |
| pwr_state | output | 3 | 0 ACTIVE, 1 SLEEP_PENDING, 2 STORING, 3 ASLEEP, 4 WAKING |

## Verification
A wrong state in this block shows at the ports almost at once. `ack_en` drops the cycle after a stray command is taken, or stays high when the stop of a valid command should have been registered. A counter that starts or stops one cycle off moves the STORING, ASLEEP or ACTIVE edge by exactly that cycle. The bench checks these edges on both sides of the boundary. A stale save-needed flag shows up as `store_req` rising on a clean memory, or never falling after `store_done`.

// File: rtl/sleep_ctl_pkg.sv
package sleep_ctl_pkg;

    typedef enum logic [2:0] {
        PWR_ACTIVE  = 3'd0,
        PWR_PENDING = 3'd1,
        PWR_STORING = 3'd2,
        PWR_ASLEEP  = 3'd3,
        PWR_WAKING  = 3'd4
    } pwr_state_e;

    typedef enum logic [2:0] {
        CP_IDLE,
        CP_ADDR_OK,
        CP_REG_OK,
        CP_CODE_OK,
        CP_DEAD
    } cmd_phase_e;

    typedef struct packed {
        logic       addr_evt;
        logic [1:0] addr_sel;
        logic       addr_rw;
        logic       reg_evt;
        logic [7:0] reg_byte;
        logic       data_evt;
        logic [7:0] data_byte;
        logic       stop_evt;
        logic       xfer_abort;
    } bus_evt_t;

    localparam logic [1:0] SEL_NONE = 2'd0;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    function automatic logic sel_is_device(input logic [1:0] sel);
        return sel != SEL_NONE;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sleep_cmd_decode.sv
module sleep_cmd_decode
    import sleep_ctl_pkg::*;
#(
    parameter logic [7:0] CMD_REG    = 8'hAA,
    parameter logic [7:0] SLEEP_CODE = 8'hB9
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  bus_evt_t ev,
    output logic     cmd_fire
);
    cmd_phase_e phase_q, phase_d;

    always_comb begin
        phase_d = phase_q;
        if (!enable || ev.xfer_abort || ev.stop_evt) begin
            phase_d = CP_IDLE;
        end else if (ev.addr_evt) begin
            phase_d = (ev.addr_sel == SEL_CTRL && !ev.addr_rw) ? CP_ADDR_OK : CP_DEAD;
        end else if (ev.reg_evt) begin
            phase_d = (phase_q == CP_ADDR_OK && ev.reg_byte == CMD_REG) ? CP_REG_OK : CP_DEAD;
        end else if (ev.data_evt) begin
            phase_d = (phase_q == CP_REG_OK && ev.data_byte == SLEEP_CODE) ? CP_CODE_OK : CP_DEAD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= CP_IDLE;
        else     phase_q <= phase_d;
    end

    assign cmd_fire = enable && ev.stop_evt && !ev.xfer_abort && (phase_q == CP_CODE_OK);

endmodule

// File: rtl/sleep_dirty_track.sv
module sleep_dirty_track (
    input  logic clk,
    input  logic rst,
    input  logic mem_wr,
    input  logic recall_evt,
    input  logic store_done,
    output logic dirty
);
    always_ff @(posedge clk) begin
        if (rst)                          dirty <= 1'b0;
        else if (mem_wr)                  dirty <= 1'b1;
        else if (recall_evt || store_done) dirty <= 1'b0;
    end
endmodule

// File: rtl/sleep_pwr_fsm.sv
module sleep_pwr_fsm
    import sleep_ctl_pkg::*;
#(
    parameter int unsigned T_SS    = 8,
    parameter int unsigned T_SLEEP = 20,
    parameter int unsigned T_WAKE  = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_fire,
    input  logic       wake_hit,
    input  logic       dirty,
    input  logic       store_done,
    output pwr_state_e state,
    output logic       store_req
);
    localparam int unsigned CNT_TOP = max2(T_SLEEP, T_WAKE);
    localparam int unsigned CW      = $clog2(CNT_TOP + 1);
    localparam logic [CW-1:0] SS_M1 = CW'(T_SS - 1);
    localparam logic [CW-1:0] SL_M1 = CW'(T_SLEEP - 1);
    localparam logic [CW-1:0] WK_M1 = CW'(T_WAKE - 1);
    localparam logic [CW-1:0] SAT   = CW'(CNT_TOP);

    pwr_state_e st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic          need_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PWR_ACTIVE:  if (cmd_fire)                   st_d = PWR_PENDING;
            PWR_PENDING: if (cnt_q == SS_M1)             st_d = PWR_STORING;
            PWR_STORING: if (!need_q && cnt_q >= SL_M1)  st_d = PWR_ASLEEP;
            PWR_ASLEEP:  if (wake_hit)                   st_d = PWR_WAKING;
            PWR_WAKING:  if (cnt_q == WK_M1)             st_d = PWR_ACTIVE;
            default:                                     st_d = PWR_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= PWR_ACTIVE;
            cnt_q  <= '0;
            need_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_d != st_q && (st_d == PWR_PENDING || st_d == PWR_WAKING))
                cnt_q <= '0;
            else if (cnt_q != SAT)
                cnt_q <= cnt_q + 1'b1;
            if (st_q == PWR_PENDING && st_d == PWR_STORING)
                need_q <= dirty;
            else if (st_q == PWR_STORING && store_done)
                need_q <= 1'b0;
        end
    end

    assign state     = st_q;
    assign store_req = (st_q == PWR_STORING) && need_q;

endmodule

// File: rtl/sleep_ctl_top.sv
module sleep_ctl_top
    import sleep_ctl_pkg::*;
#(
    parameter int unsigned T_SS       = 8,
    parameter int unsigned T_SLEEP    = 20,
    parameter int unsigned T_WAKE     = 12,
    parameter logic [7:0]  CMD_REG    = 8'hAA,
    parameter logic [7:0]  SLEEP_CODE = 8'hB9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       addr_evt,
    input  logic [1:0] addr_sel,
    input  logic       addr_rw,
    input  logic       reg_evt,
    input  logic [7:0] reg_byte,
    input  logic       data_evt,
    input  logic [7:0] data_byte,
    input  logic       stop_evt,
    input  logic       xfer_abort,
    input  logic       mem_wr,
    input  logic       recall_evt,
    input  logic       store_done,
    output logic       ack_en,
    output logic       store_req,
    output logic       busy_n,
    output logic       asleep,
    output logic [2:0] pwr_state
);
    bus_evt_t   ev;
    pwr_state_e st;
    logic       cmd_fire, dirty, wake_hit;

    assign ev = '{addr_evt: addr_evt, addr_sel: addr_sel, addr_rw: addr_rw,
                  reg_evt: reg_evt, reg_byte: reg_byte, data_evt: data_evt,
                  data_byte: data_byte, stop_evt: stop_evt, xfer_abort: xfer_abort};

    assign wake_hit = addr_evt && sel_is_device(addr_sel);

    sleep_cmd_decode #(.CMD_REG(CMD_REG), .SLEEP_CODE(SLEEP_CODE)) u_dec (
        .clk(clk), .rst(rst), .enable(ack_en), .ev(ev), .cmd_fire(cmd_fire)
    );

    sleep_dirty_track u_dirty (
        .clk(clk), .rst(rst), .mem_wr(mem_wr), .recall_evt(recall_evt),
        .store_done(store_done), .dirty(dirty)
    );

    sleep_pwr_fsm #(.T_SS(T_SS), .T_SLEEP(T_SLEEP), .T_WAKE(T_WAKE)) u_fsm (
        .clk(clk), .rst(rst), .cmd_fire(cmd_fire), .wake_hit(wake_hit),
        .dirty(dirty), .store_done(store_done), .state(st), .store_req(store_req)
    );

    assign ack_en    = (st == PWR_ACTIVE);
    assign busy_n    = !store_req;
    assign asleep    = (st == PWR_ASLEEP);
    assign pwr_state = st;

endmodule

// File: rtl/sleep_ctl_chk.sv
module sleep_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       stop_evt,
    input logic       store_done,
    input logic       ack_en,
    input logic       store_req,
    input logic       asleep,
    input logic [2:0] pwr_state
);
    assert_legal_state_R1: assert property (@(posedge clk) disable iff (rst)
        pwr_state <= 3'd4);

    assert_pending_after_stop_R2: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 3'd1 && $past(pwr_state) != 3'd1) |-> $past(stop_evt));

    assert_store_held_R5: assert property (@(posedge clk) disable iff (rst)
        (store_req && !store_done) |=> store_req);

    assert_store_release_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(store_req) |-> $past(store_done));

    assert_sleep_from_store_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(asleep) |-> $past(pwr_state) == 3'd2);

    assert_wake_from_sleep_R8: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 3'd4 && $past(pwr_state) != 3'd4) |-> $past(pwr_state) == 3'd3);

    assert_nack_off_active_R10: assert property (@(posedge clk) disable iff (rst)
        (pwr_state != 3'd0) |-> !ack_en);
endmodule

bind sleep_ctl_top sleep_ctl_chk u_chk (
    .clk(clk), .rst(rst), .stop_evt(stop_evt), .store_done(store_done),
    .ack_en(ack_en), .store_req(store_req), .asleep(asleep), .pwr_state(pwr_state)
);

// File: tb/tb_sleep_ctl_top.sv
module tb_sleep_ctl_top;
    localparam int T_SS    = 8;
    localparam int T_SLEEP = 20;
    localparam int T_WAKE  = 12;
    localparam logic [7:0] CREG  = 8'hAA;
    localparam logic [7:0] SCODE = 8'hB9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic addr_evt = 0, addr_rw = 0, reg_evt = 0, data_evt = 0, stop_evt = 0;
    logic xfer_abort = 0, mem_wr = 0, recall_evt = 0, store_done = 0;
    logic [1:0] addr_sel = 0;
    logic [7:0] reg_byte = 0, data_byte = 0;
    logic ack_en, store_req, busy_n, asleep;
    logic [2:0] pwr_state;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    sleep_ctl_top #(.T_SS(T_SS), .T_SLEEP(T_SLEEP), .T_WAKE(T_WAKE),
                    .CMD_REG(CREG), .SLEEP_CODE(SCODE)) dut (
        .clk(clk), .rst(rst), .addr_evt(addr_evt), .addr_sel(addr_sel),
        .addr_rw(addr_rw), .reg_evt(reg_evt), .reg_byte(reg_byte),
        .data_evt(data_evt), .data_byte(data_byte), .stop_evt(stop_evt),
        .xfer_abort(xfer_abort), .mem_wr(mem_wr), .recall_evt(recall_evt),
        .store_done(store_done), .ack_en(ack_en), .store_req(store_req),
        .busy_n(busy_n), .asleep(asleep), .pwr_state(pwr_state)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit is_cmd(input logic [1:0] sel, input logic rw,
                                  input logic [7:0] rg, input logic [7:0] dat,
                                  input int nd, input bit ab);
        return sel == 2'd2 && !rw && rg == CREG && dat == SCODE && nd == 1 && !ab;
    endfunction

    // Called at a negedge; returns at the negedge just after the stop edge.
    task automatic xfer(input logic [1:0] sel, input logic rw, input logic [7:0] rg,
                        input logic [7:0] dat, input int nd, input bit ab);
        addr_evt = 1; addr_sel = sel; addr_rw = rw;
        @(negedge clk); addr_evt = 0; reg_evt = 1; reg_byte = rg;
        @(negedge clk); reg_evt = 0;
        for (int i = 0; i < nd; i++) begin
            data_evt = 1; data_byte = dat;
            @(negedge clk); data_evt = 0;
        end
        if (ab) begin xfer_abort = 1; @(negedge clk); xfer_abort = 0; end
        stop_evt = 1;
        @(negedge clk); stop_evt = 0;
    endtask

    task automatic addr_only(input logic [1:0] sel);
        addr_evt = 1; addr_sel = sel; addr_rw = 0;
        @(negedge clk); addr_evt = 0;
    endtask

    task automatic pulse_wr();
        mem_wr = 1; @(negedge clk); mem_wr = 0;
    endtask

    // Clean sleep entry: checks pending, storing and asleep edges; returns asleep.
    task automatic enter_sleep_clean(input string tag);
        xfer(2'd2, 1'b0, CREG, SCODE, 1, 1'b0);
        chk({tag, " R2 pending"}, pwr_state, 1);
        chk({tag, " R10 nack pending"}, ack_en, 0);
        repeat (T_SS - 1) @(negedge clk);
        chk({tag, " R4 still pending"}, pwr_state, 1);
        @(negedge clk);
        chk({tag, " R4 storing"}, pwr_state, 2);
        chk({tag, " R6 no store_req"}, store_req, 0);
        repeat (T_SLEEP - T_SS - 1) @(negedge clk);
        chk({tag, " R7 not yet asleep"}, asleep, 0);
        @(negedge clk);
        chk({tag, " R7 asleep"}, asleep, 1);
        chk({tag, " R7 state"}, pwr_state, 3);
    endtask

    task automatic wake(input logic [1:0] sel, input string tag);
        addr_only(sel);
        chk({tag, " R8 waking"}, pwr_state, 4);
        chk({tag, " R10 nack waking"}, ack_en, 0);
        repeat (T_WAKE - 1) @(negedge clk);
        chk({tag, " R9 still waking"}, pwr_state, 4);
        @(negedge clk);
        chk({tag, " R9 active"}, pwr_state, 0);
        chk({tag, " R9 ack"}, ack_en, 1);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 200000) begin @(posedge clk); cyc++; end
        fails++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 state", pwr_state, 0);
        chk("R1 ack_en", ack_en, 1);
        chk("R1 store_req", store_req, 0);
        chk("R1 busy_n", busy_n, 1);
        chk("R1 asleep", asleep, 0);

        // Directed near-misses (R3)
        xfer(2'd1, 1'b0, CREG, SCODE, 1, 1'b0); chk("R3 wrong sel", pwr_state, 0);
        xfer(2'd2, 1'b1, CREG, SCODE, 1, 1'b0); chk("R3 read", pwr_state, 0);
        xfer(2'd2, 1'b0, 8'hAB, SCODE, 1, 1'b0); chk("R3 other reg", pwr_state, 0);
        xfer(2'd2, 1'b0, CREG, 8'hB8, 1, 1'b0); chk("R3 other data", pwr_state, 0);
        xfer(2'd2, 1'b0, CREG, SCODE, 2, 1'b0); chk("R3 two data", pwr_state, 0);
        xfer(2'd2, 1'b0, CREG, SCODE, 1, 1'b1); chk("R3 abort", pwr_state, 0);

        // Random non-command traffic (R3)
        for (int n = 0; n < 30; n++) begin
            logic [1:0] s  = 2'($urandom % 4);
            logic       rw = 1'($urandom % 2);
            logic [7:0] rg = ($urandom % 2) ? CREG : 8'($urandom);
            logic [7:0] dt = ($urandom % 2) ? SCODE : 8'($urandom);
            int         nd = 1 + int'($urandom % 2);
            bit         ab = ($urandom % 4) == 0;
            if (is_cmd(s, rw, rg, dt, nd, ab)) ab = 1;
            xfer(s, rw, rg, dt, nd, ab);
            chk("R3 random traffic", pwr_state, 0);
        end

        // Clean sleep, ignored address, wake by control identity
        enter_sleep_clean("clean1");
        addr_only(2'd0);
        chk("R8 sel0 ignored", pwr_state, 3);
        xfer(2'd2, 1'b0, CREG, SCODE, 1, 1'b0);
        chk("R10 nack asleep", ack_en, 0);
        chk("R8 xfer wakes", pwr_state, 4);
        repeat (T_WAKE) @(negedge clk);
        chk("R9 back active", pwr_state, 0);

        // Wake interval not restarted by a second address
        enter_sleep_clean("clean2");
        addr_only(2'd1);
        chk("R8 waking sel1", pwr_state, 4);
        addr_only(2'd3);
        repeat (T_WAKE - 2) @(negedge clk);
        chk("R9 no restart still waking", pwr_state, 4);
        @(negedge clk);
        chk("R9 no restart active", pwr_state, 0);

        // Dirty: save requested and held past T_SLEEP
        pulse_wr();
        xfer(2'd2, 1'b0, CREG, SCODE, 1, 1'b0);
        repeat (T_SS) @(negedge clk);
        chk("R4 storing dirty", pwr_state, 2);
        chk("R5 store_req", store_req, 1);
        chk("R5 busy_n low", busy_n, 0);
        repeat (T_SLEEP - T_SS + 5) @(negedge clk);
        chk("R7 waits for save", pwr_state, 2);
        chk("R5 held", store_req, 1);
        store_done = 1; @(negedge clk); store_done = 0;
        chk("R5 released", store_req, 0);
        chk("R5 busy_n high", busy_n, 1);
        chk("R7 one cycle after done", pwr_state, 2);
        @(negedge clk);
        chk("R7 asleep after save", asleep, 1);
        wake(2'd3, "w3");

        // Save cleared dirty; next entry is clean
        enter_sleep_clean("after_save");
        wake(2'd2, "w2");

        // Recall clears dirty
        pulse_wr();
        recall_evt = 1; @(negedge clk); recall_evt = 0;
        enter_sleep_clean("after_recall");
        wake(2'd1, "w1");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule